// File: doc/BRIEF.md
# ADC Scan List Sequencer

This block drives one or two analog converter front ends through a programmable list of eight sample slots. Each slot carries a 3-bit channel selector. A scan trigger makes the block capture its configuration and then issue a start strobe, with a channel, a slot index and a single-ended/differential flag, for each step of the scan. It waits for each converter's conversion-complete handshake before it moves to the next step.

In sequential mode, converter A walks the slots in ascending order from slot 0. In parallel mode, converter A takes slots 0 to 3 and converter B takes slots 4 to 7, one pair per step and in lockstep. A per-slot disable mask truncates the scan. Sequential scans end before the first disabled slot. A parallel scan ends before step k when slot k or slot k+4 is disabled. After the last completed step the block emits a one-cycle scan-done pulse and returns to idle.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, start_a_o, start_b_o and scan_done_o are low. No start is issued until a trigger arrives.
- R2: In sequential mode (par_mode_i=0), converter A receives slots 0,1,2,... in ascending order. For slot k, slot_a_o=k and the selector is read from slots_i bits [3k+2:3k]. start_b_o stays low.
- R3: In sequential mode, the scan converts slots 0 to f-1, where f is the lowest index with dis_i[f]=1. If no bit is set, all eight slots are converted.
- R4: In parallel mode (par_mode_i=1), step k asserts start_a_o and start_b_o in the same cycle. slot_a_o is k and slot_b_o is k+4, each with its own slot's selector.
- R5: In parallel mode, the scan performs steps 0 to k-1, where k is the lowest index in 0..3 with dis_i[k]=1 or dis_i[k+4]=1. If there is no such index, all four steps are performed.
- R6: diff_i[0] sets differential operation for converter A and diff_i[1] for converter B. In single-ended operation the channel output equals the selector and the diff flag is 0. In differential operation the channel output is the even input of the pair (selector with bit 0 cleared) and the diff flag is 1.
- R7: After a step's start, the block issues no further start until done_a_i has been seen. In parallel mode it also waits for done_b_i. The two done pulses may arrive in different cycles, in either order.
- R8: A trigger that arrives while a scan is active is ignored and does not start another scan.
- R9: The slots, mode, diff setting and mask are sampled in the cycle the trigger is accepted. Changes to them during the scan have no effect.
- R10: scan_done_o is high for exactly one cycle, in the cycle after the last step's completion is seen. If the first step is disabled, it comes in the cycle after the trigger and no start is issued.
- R11: Each start strobe is high for a single cycle per step. The first start comes in the cycle after the accepted trigger, and each later start comes in the cycle after the completion that ends the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Scan trigger, accepted only when idle |
| par_mode_i | input | 1 | 0 sequential, 1 parallel |
| diff_i | input | 2 | Differential enable, bit 0 converter A, bit 1 converter B |
| slots_i | input | 24 | Slot selectors, slot k at bits [3k+2:3k] |
| dis_i | input | 8 | Per-slot disable mask |
| done_a_i | input | 1 | Conversion complete from converter A |
| done_b_i | input | 1 | Conversion complete from converter B |
| start_a_o | output | 1 | Start strobe to converter A |
| chan_a_o | output | 3 | Input channel for converter A |
| diff_a_o | output | 1 | Differential flag for converter A |
| slot_a_o | output | 3 | Slot index for converter A |
| start_b_o | output | 1 | Start strobe to converter B |
| chan_b_o | output | 3 | Input channel for converter B |
| diff_b_o | output | 1 | Differential flag for converter B |
| slot_b_o | output | 3 | Slot index for converter B |
| scan_done_o | output | 1 | One-cycle end-of-scan pulse |

## Verification
The hardest case to reach is a parallel step where the two converters finish in different cycles. Only that case shows whether the block holds the next step until the later handshake. The bench draws independent completion delays for A and B at every step, and it checks in every intervening cycle that no start appears. To test configuration capture and trigger rejection, it scrambles the slot, mask and mode inputs right after each accepted trigger and pulses the trigger mid-scan. The expected sequence comes from the values at the trigger.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } scan_state_e;
endpackage

// File: rtl/scan_cfg_latch.sv
module scan_cfg_latch #(
  parameter int NUM_SLOTS = 8,
  parameter int SEL_W     = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              cap_i,
  input  logic                              busy_i,
  input  logic [NUM_SLOTS*SEL_W-1:0]        slots_i,
  input  logic [NUM_SLOTS-1:0]              dis_i,
  input  logic                              par_i,
  input  logic [1:0]                        diff_i,
  output logic [NUM_SLOTS-1:0][SEL_W-1:0]   slots_o,
  output logic [NUM_SLOTS-1:0]              dis_o,
  output logic                              par_o,
  output logic [1:0]                        diff_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slots_o <= '0;
      dis_o   <= '0;
      par_o   <= 1'b0;
      diff_o  <= '0;
    end else if (cap_i) begin
      slots_o <= slots_i;
      dis_o   <= dis_i;
      par_o   <= par_i;
      diff_o  <= diff_i;
    end
  end

  // R9: configuration frozen while a scan runs
  a_r9_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !cap_i) |=> ($stable(slots_o) && $stable(dis_o) && $stable(par_o) && $stable(diff_o)));
endmodule

// File: rtl/scan_step_ctrl.sv
module scan_step_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int HALF     = NUM_SLOTS / 2,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int STEP_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 trig_i,
  input  logic                 par_i,
  input  logic [NUM_SLOTS-1:0] dis_i,
  input  logic                 done_a_i,
  input  logic                 done_b_i,
  output logic                 cap_o,
  output logic                 busy_o,
  output logic [IDX_W-1:0]     step_o,
  output logic                 start_a_o,
  output logic                 start_b_o,
  output logic                 scan_done_o
);
  scan_state_e      state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              got_a_q, got_a_d, got_b_q, got_b_d;
  logic [STEP_W-1:0] lim_seq, lim_par, lim;
  logic              a_ok, b_ok;

  // first disabled slot bounds the scan
  always_comb begin
    lim_seq = STEP_W'(NUM_SLOTS);
    for (int i = NUM_SLOTS - 1; i >= 0; i--)
      if (dis_i[i]) lim_seq = STEP_W'(i);
  end

  always_comb begin
    lim_par = STEP_W'(HALF);
    for (int i = HALF - 1; i >= 0; i--)
      if (dis_i[i] || dis_i[i+HALF]) lim_par = STEP_W'(i);
  end

  assign lim  = par_i ? lim_par : lim_seq;
  assign a_ok = got_a_q || done_a_i;
  assign b_ok = !par_i || got_b_q || done_b_i;

  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    got_a_d     = got_a_q;
    got_b_d     = got_b_q;
    cap_o       = 1'b0;
    start_a_o   = 1'b0;
    start_b_o   = 1'b0;
    scan_done_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          cap_o   = 1'b1;
          step_d  = '0;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (step_q >= lim) begin
          scan_done_o = 1'b1;
          step_d      = '0;
          state_d     = ST_IDLE;
        end else begin
          start_a_o = 1'b1;
          start_b_o = par_i;
          got_a_d   = 1'b0;
          got_b_d   = 1'b0;
          state_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (a_ok && b_ok) begin
          step_d  = step_q + 1'b1;
          got_a_d = 1'b0;
          got_b_d = 1'b0;
          state_d = ST_ISSUE;
        end else begin
          got_a_d = a_ok;
          got_b_d = got_b_q || done_b_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      got_a_q <= 1'b0;
      got_b_q <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      got_a_q <= got_a_d;
      got_b_q <= got_b_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign step_o = step_q[IDX_W-1:0];

  logic [IDX_W-1:0] idx_lo, idx_hi;
  assign idx_lo = step_q[IDX_W-1:0];
  assign idx_hi = step_q[IDX_W-1:0] + IDX_W'(HALF);

  a_r11_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_a_o |=> !start_a_o);
  a_r4_b_with_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_b_o |-> (start_a_o && par_i));
  a_r3_seq_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_a_o && !par_i) |-> !dis_i[idx_lo]);
  a_r5_par_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_a_o && par_i) |-> (!dis_i[idx_lo] && !dis_i[idx_hi] && step_q < STEP_W'(HALF)));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> (!scan_done_o && !busy_o && step_q == '0));
  a_r8_no_recapture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cap_o);
endmodule

// File: rtl/scan_chan_map.sv
module scan_chan_map #(
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             diff_i,
  output logic [SEL_W-1:0] chan_o,
  output logic             diff_o
);
  // differential: positive leg is the even input of the pair
  assign chan_o = diff_i ? {sel_i[SEL_W-1:1], 1'b0} : sel_i;
  assign diff_o = diff_i;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_SLOTS = 8,
  parameter int SEL_W     = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int HALF     = NUM_SLOTS / 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       trig_i,
  input  logic                       par_mode_i,
  input  logic [1:0]                 diff_i,
  input  logic [NUM_SLOTS*SEL_W-1:0] slots_i,
  input  logic [NUM_SLOTS-1:0]       dis_i,
  input  logic                       done_a_i,
  input  logic                       done_b_i,
  output logic                       start_a_o,
  output logic [SEL_W-1:0]           chan_a_o,
  output logic                       diff_a_o,
  output logic [IDX_W-1:0]           slot_a_o,
  output logic                       start_b_o,
  output logic [SEL_W-1:0]           chan_b_o,
  output logic                       diff_b_o,
  output logic [IDX_W-1:0]           slot_b_o,
  output logic                       scan_done_o
);
  logic                            cap, busy;
  logic [IDX_W-1:0]                step;
  logic [NUM_SLOTS-1:0][SEL_W-1:0] slots_q;
  logic [NUM_SLOTS-1:0]            dis_q;
  logic                            par_q;
  logic [1:0]                      diff_q;

  scan_cfg_latch #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .busy_i  (busy),
    .slots_i (slots_i),
    .dis_i   (dis_i),
    .par_i   (par_mode_i),
    .diff_i  (diff_i),
    .slots_o (slots_q),
    .dis_o   (dis_q),
    .par_o   (par_q),
    .diff_o  (diff_q)
  );

  scan_step_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .par_i       (par_q),
    .dis_i       (dis_q),
    .done_a_i    (done_a_i),
    .done_b_i    (done_b_i),
    .cap_o       (cap),
    .busy_o      (busy),
    .step_o      (step),
    .start_a_o   (start_a_o),
    .start_b_o   (start_b_o),
    .scan_done_o (scan_done_o)
  );

  logic [1:0][IDX_W-1:0] slot_idx;
  logic [1:0][SEL_W-1:0] chan;
  logic [1:0]            dflag;

  assign slot_idx[0] = step;
  assign slot_idx[1] = step + IDX_W'(HALF);

  for (genvar g = 0; g < 2; g++) begin : g_conv
    scan_chan_map #(.SEL_W(SEL_W)) u_map (
      .sel_i  (slots_q[slot_idx[g]]),
      .diff_i (diff_q[g]),
      .chan_o (chan[g]),
      .diff_o (dflag[g])
    );
  end

  assign slot_a_o = slot_idx[0];
  assign slot_b_o = slot_idx[1];
  assign chan_a_o = chan[0];
  assign chan_b_o = chan[1];
  assign diff_a_o = dflag[0];
  assign diff_b_o = dflag[1];

  // R1: no activity without a scan in progress
  a_r1_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!start_a_o && !start_b_o && !scan_done_o));
  // R6: differential channel is always the even leg
  a_r6_even_leg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_a_o && diff_a_o) |-> !chan_a_o[0]);
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0, par = 1'b0, done_a = 1'b0, done_b = 1'b0;
  logic [1:0]  diff = '0;
  logic [23:0] slots = '0;
  logic [7:0]  dis = '0;
  logic        start_a, start_b, diff_a, diff_b, scan_done;
  logic [2:0]  chan_a, chan_b, slot_a, slot_b;
  int          n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_scan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .par_mode_i(par), .diff_i(diff),
    .slots_i(slots), .dis_i(dis), .done_a_i(done_a), .done_b_i(done_b),
    .start_a_o(start_a), .chan_a_o(chan_a), .diff_a_o(diff_a), .slot_a_o(slot_a),
    .start_b_o(start_b), .chan_b_o(chan_b), .diff_b_o(diff_b), .slot_b_o(slot_b),
    .scan_done_o(scan_done)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_chan(input logic [2:0] sel, input logic d);
    return d ? {sel[2:1], 1'b0} : sel;
  endfunction

  // lim = number of steps the bench expects from the construction of the mask
  task automatic run_scan(input logic [23:0] sl, input logic [7:0] ds, input logic pm,
                          input logic [1:0] df, input int lim, input bit trig_mid);
    @(negedge clk);
    slots = sl; dis = ds; par = pm; diff = df; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    slots = 24'($urandom); dis = 8'($urandom); par = ~pm; diff = ~df; // R9
    for (int s = 0; s < lim; s++) begin
      logic [2:0] sa, sb;
      int da, db, mx;
      sa = sl[3*s +: 3];
      sb = sl[3*(s+4) +: 3];
      chk(start_a === 1'b1, "R11", "start_a at step", int'(start_a), 1);
      chk(slot_a === 3'(s), pm ? "R4" : "R2", "slot_a", int'(slot_a), s);
      chk(chan_a === exp_chan(sa, df[0]), "R6", "chan_a", int'(chan_a), int'(exp_chan(sa, df[0])));
      chk(diff_a === df[0], "R6", "diff_a", int'(diff_a), int'(df[0]));
      chk(start_b === pm, pm ? "R4" : "R2", "start_b", int'(start_b), int'(pm));
      chk(scan_done === 1'b0, "R10", "early done", int'(scan_done), 0);
      if (pm) begin
        chk(slot_b === 3'(s + 4), "R4", "slot_b", int'(slot_b), s + 4);
        chk(chan_b === exp_chan(sb, df[1]), "R6", "chan_b", int'(chan_b), int'(exp_chan(sb, df[1])));
        chk(diff_b === df[1], "R6", "diff_b", int'(diff_b), int'(df[1]));
      end
      da = 1 + int'($urandom % 3);
      db = pm ? 1 + int'($urandom % 3) : 0;
      mx = (da > db) ? da : db;
      for (int c = 1; c <= mx; c++) begin
        @(negedge clk);
        chk(start_a === 1'b0, "R7", "start before completion", int'(start_a), 0);
        chk(scan_done === 1'b0, "R7", "done before completion", int'(scan_done), 0);
        done_a = (c == da);
        done_b = (c == db);
        trig   = trig_mid && (c == 1); // R8
      end
      @(negedge clk);
      done_a = 1'b0; done_b = 1'b0; trig = 1'b0;
    end
    chk(scan_done === 1'b1, (lim == 0) ? "R10" : (pm ? "R5" : "R3"), "scan_done at end", int'(scan_done), 1);
    chk(start_a === 1'b0, pm ? "R5" : "R3", "start past end", int'(start_a), 0);
    @(negedge clk);
    chk(scan_done === 1'b0, "R10", "done width", int'(scan_done), 0);
    chk(start_a === 1'b0, "R8", "restart after mid trig", int'(start_a), 0);
    @(negedge clk);
    chk(start_a === 1'b0 && scan_done === 1'b0, "R8", "idle after scan", int'(start_a), 0);
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(start_a === 1'b0 && start_b === 1'b0 && scan_done === 1'b0, "R1", "outputs in reset", int'(start_a), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(start_a === 1'b0 && start_b === 1'b0 && scan_done === 1'b0, "R1", "idle without trigger", int'(start_a), 0);

    // sequential sweep: first disabled slot f (8 = none), R2 R3
    for (int f = 0; f <= 8; f++) begin
      for (int d = 0; d < 2; d++) begin
        for (int rep = 0; rep < 2; rep++) begin
          logic [7:0] m;
          m = (f < 8) ? (8'(1 << f) | (8'($urandom) & ~8'((1 << (f + 1)) - 1))) : 8'h00;
          run_scan(24'($urandom), m, 1'b0, {1'b0, d[0]}, f, rep == 1);
        end
      end
    end

    // parallel sweep: blocking step k (4 = none), disable in low or high half, R4 R5
    for (int k = 0; k <= 4; k++) begin
      for (int h = 0; h < 2; h++) begin
        for (int d = 0; d < 4; d++) begin
          logic [7:0] m;
          logic [3:0] up;
          up = (k < 4) ? (4'($urandom) & ~4'((1 << (k + 1)) - 1)) : 4'h0;
          m  = {up, 4'($urandom) & ~4'((1 << (k + 1)) - 1)} & ((k < 4) ? 8'hFF : 8'h00);
          if (k < 4) m[k + 4*h] = 1'b1;
          run_scan(24'($urandom), m, 1'b1, 2'(d), k, d[0]);
        end
      end
    end

    // all selector codes in both leg modes, full scans, R6
    run_scan({3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 8'h00, 1'b0, 2'b00, 8, 1'b0);
    run_scan({3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0}, 8'h00, 1'b0, 2'b01, 8, 1'b0);
    run_scan({3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7}, 8'h00, 1'b1, 2'b10, 4, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule